// File: doc/BRIEF.md
# AC Data Bus Inversion Codec

This block codes a wide DRAM data bus with transition-limiting data bus inversion. The bus is cut into byte lanes, and each lane has one inversion line of its own. For every transfer beat a lane chooses one of two forms: it sends the byte as it is with the inversion line low, or it sends the complement with the line high. The choice is the one that toggles no more than half of the lane's nine wires, measured against the word that lane last drove. That history is kept in registers and holds across idle cycles and across separate bursts, so the first beat of a new burst is coded against the last beat of the one before.

The transmit side registers the coded word, so the wire outputs are the lane history itself. A separate combinational receive path takes a coded word with its inversion bits and gives back the original data. A controller drives `tx_data` with `tx_valid` high for each beat and sends `wire_dq`/`wire_inv` to the pads. Words that come back from the pads go to `rx_dq`/`rx_inv`.

Top module: `dbi_ac_codec`

## Requirements
- R1: The bus is LANES lanes of LANE_W bits (defaults 16 and 8). Lane k covers data bits [LANE_W*k+LANE_W-1 : LANE_W*k] and owns inversion bit k of `wire_inv` and `rx_inv`.
- R2: From one driven beat to the next, at most (LANE_W+1)/2 of a lane's LANE_W+1 wires toggle. The wires are its data bits plus its inversion bit, so the limit is 4 of 9 by default.
- R3: Let t be the number of a lane's wires that would toggle if the byte went out as it is with the inversion bit 0. If t >= 5 (default width), the lane drives the complement of the byte with inversion bit 1. Otherwise it drives the byte as it is with inversion bit 0, and t = 4 therefore gives no inversion.
- R4: While `rst_n` is low at a clock edge, `wire_dq`, `wire_inv` and `wire_vld` go to all zeros, and the lane history becomes all zeros.
- R5: A clock edge with `tx_valid` low leaves `wire_dq` and `wire_inv` unchanged. The next beat is coded against the last word driven, however many idle cycles lie between.
- R6: `rx_data` is `rx_dq` with each lane complemented where its `rx_inv` bit is 1 and passed through where it is 0. The path is combinational.
- R7: The coded word of a beat, and `wire_vld` = 1, appear one clock after the edge at which `tx_valid` was high. `wire_vld` is 0 after an edge with `tx_valid` low.
- R8: Each lane decides on its own data and history alone, so the data in one lane never changes the coding of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | A transfer beat is presented on `tx_data` |
| tx_data | input | LANES*LANE_W | Unencoded transmit data |
| wire_dq | output | LANES*LANE_W | Coded data driven toward the pads |
| wire_inv | output | LANES | Per-lane inversion lines driven with `wire_dq` |
| wire_vld | output | 1 | `wire_dq`/`wire_inv` carry a fresh beat |
| rx_dq | input | LANES*LANE_W | Coded data received from the pads |
| rx_inv | input | LANES | Received per-lane inversion lines |
| rx_data | output | LANES*LANE_W | Restored receive data |

## Verification
A full flip from the reset state (t = 8) has to invert. The t = 4 and t = 5 words pin down the exact threshold, and a second word after an inverted beat shows that the inversion line's own toggle counts toward t. One active lane among quiet ones separates per-lane decisions from a bus-wide one. An idle gap before a beat that only inverts when coded against the retained word proves the history survives between bursts. A long pseudo-random stream, looped back to the receive path, tests the toggle limit and the round trip against a lane model written from the rule, and fixed receive words with mixed inversion bits test the decoder by itself.

// File: rtl/dbi_ac_pkg.sv
// Package: dbi_ac_pkg
// Defaults and shared types for the transition-limiting inversion codec.
// Assumes nothing beyond a common clock for all lanes.
package dbi_ac_pkg;
    localparam int unsigned DEF_LANES  = 16;
    localparam int unsigned DEF_LANE_W = 8;

    // Polarity a lane chose for its current beat
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } lane_pol_e;
endpackage

// File: rtl/dbi_ac_lane_enc.sv
// Module: dbi_ac_lane_enc
// Purely combinational inversion decision for one lane. It counts how many
// of the lane's LANE_W+1 wires would change if the byte went out as it is
// with the inversion bit low, and picks the complement when that count
// exceeds half the wires. Assumes prev_* hold the word last driven.
module dbi_ac_lane_enc
    import dbi_ac_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic [LANE_W-1:0] data,
    input  logic [LANE_W-1:0] prev_dq,
    input  logic              prev_inv,
    output logic [LANE_W-1:0] enc_dq,
    output logic              enc_inv
);
    localparam int unsigned WIRES  = LANE_W + 1;
    localparam int unsigned CNT_W  = $clog2(WIRES + 1);
    localparam int unsigned THRESH = WIRES / 2 + 1;

    logic [CNT_W-1:0] raw_toggles;
    lane_pol_e        pol;

    // Count wire changes for the uninverted form
    always_comb begin
        raw_toggles = CNT_W'(prev_inv);
        for (int b = 0; b < int'(LANE_W); b++) begin
            raw_toggles = raw_toggles + CNT_W'(data[b] ^ prev_dq[b]);
        end
    end

    // Choose polarity and form the coded word
    always_comb begin
        pol     = (raw_toggles >= CNT_W'(THRESH)) ? POL_INV : POL_TRUE;
        enc_inv = (pol == POL_INV);
        enc_dq  = (pol == POL_INV) ? ~data : data;
    end
endmodule

// File: rtl/dbi_ac_lane_reg.sv
// Module: dbi_ac_lane_reg
// History register for one lane: holds the last driven data and inversion
// bit, which double as the wire outputs. Loads only on a valid beat; the
// synchronous active-low reset clears it.
module dbi_ac_lane_reg
    import dbi_ac_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] d_dq,
    input  logic              d_inv,
    output logic [LANE_W-1:0] q_dq,
    output logic              q_inv
);
    // Capture the coded word on a beat, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_dq  <= '0;
            q_inv <= 1'b0;
        end else if (load) begin
            q_dq  <= d_dq;
            q_inv <= d_inv;
        end
    end
endmodule

// File: rtl/dbi_ac_lane_dec.sv
// Module: dbi_ac_lane_dec
// Combinational receive path for one lane: restores the byte by
// complementing it when the received inversion bit is set.
module dbi_ac_lane_dec
    import dbi_ac_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic [LANE_W-1:0] in_dq,
    input  logic              in_inv,
    output logic [LANE_W-1:0] out_data
);
    // Undo the lane polarity
    always_comb begin
        out_data = in_dq ^ {LANE_W{in_inv}};
    end
endmodule

// File: rtl/dbi_ac_codec.sv
// Module: dbi_ac_codec
// Top of the transition-limiting inversion codec. It instantiates one
// encoder, history register and decoder per lane and registers a beat
// valid flag. Assumes a single clock and a synchronous active-low reset.
module dbi_ac_codec
    import dbi_ac_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_valid,
    input  logic [LANES*LANE_W-1:0] tx_data,
    output logic [LANES*LANE_W-1:0] wire_dq,
    output logic [LANES-1:0]        wire_inv,
    output logic                    wire_vld,
    input  logic [LANES*LANE_W-1:0] rx_dq,
    input  logic [LANES-1:0]        rx_inv,
    output logic [LANES*LANE_W-1:0] rx_data
);
    localparam int unsigned BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] enc_dq;
    logic [LANES-1:0] enc_inv;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        dbi_ac_lane_enc #(.LANE_W(LANE_W)) u_enc (
            .data     (tx_data[g*LANE_W +: LANE_W]),
            .prev_dq  (wire_dq[g*LANE_W +: LANE_W]),
            .prev_inv (wire_inv[g]),
            .enc_dq   (enc_dq[g*LANE_W +: LANE_W]),
            .enc_inv  (enc_inv[g])
        );

        dbi_ac_lane_reg #(.LANE_W(LANE_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (tx_valid),
            .d_dq  (enc_dq[g*LANE_W +: LANE_W]),
            .d_inv (enc_inv[g]),
            .q_dq  (wire_dq[g*LANE_W +: LANE_W]),
            .q_inv (wire_inv[g])
        );

        dbi_ac_lane_dec #(.LANE_W(LANE_W)) u_dec (
            .in_dq    (rx_dq[g*LANE_W +: LANE_W]),
            .in_inv   (rx_inv[g]),
            .out_data (rx_data[g*LANE_W +: LANE_W])
        );
    end

    // Flag that the wire word is a fresh beat
    always_ff @(posedge clk) begin
        if (!rst_n) wire_vld <= 1'b0;
        else        wire_vld <= tx_valid;
    end
endmodule

// File: rtl/dbi_ac_codec_chk.sv
// Module: dbi_ac_codec_chk
// Assertion checker bound to dbi_ac_codec. It watches only the ports.
module dbi_ac_codec_chk #(
    parameter int unsigned LANES  = 16,
    parameter int unsigned LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tx_valid,
    input logic [LANES*LANE_W-1:0] tx_data,
    input logic [LANES*LANE_W-1:0] wire_dq,
    input logic [LANES-1:0]        wire_inv,
    input logic                    wire_vld,
    input logic [LANES*LANE_W-1:0] rx_dq,
    input logic [LANES-1:0]        rx_inv,
    input logic [LANES*LANE_W-1:0] rx_data
);
    localparam int unsigned LIMIT = (LANE_W + 1) / 2;

    logic armed       = 1'b0;
    logic was_in_rst  = 1'b0;
    logic [LANES*LANE_W-1:0] last_dq  = '0;
    logic [LANES-1:0]        last_inv = '0;
    logic over_limit;

    // Track first edge, reset history and the previous wire word
    always_ff @(posedge clk) begin
        armed      <= 1'b1;
        was_in_rst <= !rst_n;
        last_dq    <= wire_dq;
        last_inv   <= wire_inv;
    end

    // Flag any lane whose wires changed more than the limit
    always_comb begin
        over_limit = 1'b0;
        for (int l = 0; l < int'(LANES); l++) begin
            if ($countones({wire_dq[l*LANE_W +: LANE_W], wire_inv[l]} ^
                           {last_dq[l*LANE_W +: LANE_W], last_inv[l]}) > LIMIT)
                over_limit = 1'b1;
        end
    end

    // Check the reset state one edge after reset was seen
    always_ff @(posedge clk) begin
        if (armed && was_in_rst && rst_n) begin
            AST_RESET_CLEAR: assert (wire_dq == '0 && wire_inv == '0 && !wire_vld); // R4
        end
    end

    AST_TOGGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (wire_vld && !was_in_rst) |-> !over_limit); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tx_valid |=> ($stable(wire_dq) && $stable(wire_inv))); // R5
    AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |=> wire_vld); // R7
    AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n) !tx_valid |=> !wire_vld); // R7
    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n) (wire_vld && !was_in_rst && rx_dq == wire_dq && rx_inv == wire_inv) |-> rx_data == $past(tx_data)); // R6
endmodule

bind dbi_ac_codec dbi_ac_codec_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .wire_dq  (wire_dq),
    .wire_inv (wire_inv),
    .wire_vld (wire_vld),
    .rx_dq    (rx_dq),
    .rx_inv   (rx_inv),
    .rx_data  (rx_data)
);

// File: tb/dbi_ac_codec_tb.sv
// Directed bench for dbi_ac_codec: one task per scenario, each checking
// its own results against a lane model built from the requirements.
module dbi_ac_codec_tb;
    localparam int  LANES  = 16;
    localparam int  LANE_W = 8;
    localparam int  BUS_W  = LANES * LANE_W;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_valid = 1'b0;
    logic [BUS_W-1:0] tx_data = '0;
    logic [BUS_W-1:0] wire_dq;
    logic [LANES-1:0] wire_inv;
    logic             wire_vld;
    logic             loopback = 1'b1;
    logic [BUS_W-1:0] ext_dq = '0;
    logic [LANES-1:0] ext_inv = '0;
    logic [BUS_W-1:0] rx_dq;
    logic [LANES-1:0] rx_inv;
    logic [BUS_W-1:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Bench model of the lane history
    logic [BUS_W-1:0] m_dq  = '0;
    logic [LANES-1:0] m_inv = '0;

    assign rx_dq  = loopback ? wire_dq  : ext_dq;
    assign rx_inv = loopback ? wire_inv : ext_inv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbi_ac_codec #(.LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .wire_dq  (wire_dq),
        .wire_inv (wire_inv),
        .wire_vld (wire_vld),
        .rx_dq    (rx_dq),
        .rx_inv   (rx_inv),
        .rx_data  (rx_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model: code one beat per the R3 rule against the model history
    task automatic model_beat(input logic [BUS_W-1:0] d);
        for (int l = 0; l < LANES; l++) begin
            int t;
            t = $countones(d[l*LANE_W +: LANE_W] ^ m_dq[l*LANE_W +: LANE_W]) + int'(m_inv[l]);
            if (t >= 5) begin
                m_dq[l*LANE_W +: LANE_W] = ~d[l*LANE_W +: LANE_W];
                m_inv[l] = 1'b1;
            end else begin
                m_dq[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
                m_inv[l] = 1'b0;
            end
        end
    endtask

    function automatic int max_toggles(input logic [BUS_W-1:0] a_dq, input logic [LANES-1:0] a_inv,
                                       input logic [BUS_W-1:0] b_dq, input logic [LANES-1:0] b_inv);
        int mx = 0;
        for (int l = 0; l < LANES; l++) begin
            int c;
            c = $countones({a_dq[l*LANE_W +: LANE_W], a_inv[l]} ^ {b_dq[l*LANE_W +: LANE_W], b_inv[l]});
            if (c > mx) mx = c;
        end
        return mx;
    endfunction

    // Drive one beat, check coding, toggle limit, round trip and valid
    task automatic send_beat(input logic [BUS_W-1:0] d, input string req);
        logic [BUS_W-1:0] p_dq;
        logic [LANES-1:0] p_inv;
        int mx;
        p_dq  = wire_dq;
        p_inv = wire_inv;
        tx_data  = d;
        tx_valid = 1'b1;
        model_beat(d);
        @(negedge clk);
        tx_valid = 1'b0;
        check(wire_dq == m_dq, req, "R3 coded data", wire_dq, m_dq);
        check(wire_inv == m_inv, req, "R3 inversion bits", BUS_W'(wire_inv), BUS_W'(m_inv));
        mx = max_toggles(wire_dq, wire_inv, p_dq, p_inv);
        check(mx <= 4, req, "R2 lane toggles", BUS_W'(mx), BUS_W'(4));
        check(rx_data == d, req, "R6 round trip", rx_data, d);
        check(wire_vld == 1'b1, req, "R7 valid after beat", BUS_W'(wire_vld), BUS_W'(1));
    endtask

    task automatic apply_reset();
        tx_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_dq  = '0;
        m_inv = '0;
    endtask

    task automatic t_reset();
        apply_reset();
        check(wire_dq == '0, "R4", "data after reset", wire_dq, '0);
        check(wire_inv == '0 && wire_vld == 1'b0, "R4", "inv/vld after reset",
              BUS_W'({wire_vld, wire_inv}), '0);
    endtask

    task automatic t_full_flip();
        apply_reset();
        send_beat({BUS_W{1'b1}}, "R3 full flip");
        check(wire_dq == '0 && wire_inv == {LANES{1'b1}}, "R3", "t=8 inverts",
              BUS_W'({wire_inv, wire_dq[15:0]}), BUS_W'({{LANES{1'b1}}, 16'h0}));
        @(negedge clk);
        check(wire_vld == 1'b0, "R7", "valid drops when idle", BUS_W'(wire_vld), '0);
    endtask

    task automatic t_threshold();
        apply_reset();
        send_beat({LANES{8'h0F}}, "R3 t=4");
        check(wire_dq == {LANES{8'h0F}} && wire_inv == '0, "R3", "t=4 stays true", wire_dq, {LANES{8'h0F}});
        send_beat({LANES{8'hF0}}, "R3 after true");
        check(wire_dq == {LANES{8'h0F}} && wire_inv == {LANES{1'b1}}, "R3", "t=8 inverts to 0F", wire_dq, {LANES{8'h0F}});
        // Against 0F with inv=1: 0x0E gives 1 data + inv = 2 -> true
        send_beat({LANES{8'h0E}}, "R3 inv bit counted");
        check(wire_dq == {LANES{8'h0E}} && wire_inv == '0, "R3", "inv toggle counted", wire_dq, {LANES{8'h0E}});
        apply_reset();
        send_beat({LANES{8'h1F}}, "R3 t=5");
        check(wire_dq == {LANES{8'hE0}} && wire_inv == {LANES{1'b1}}, "R3", "t=5 inverts", wire_dq, {LANES{8'hE0}});
    endtask

    task automatic t_lane_independent();
        logic [BUS_W-1:0] d;
        apply_reset();
        d = '0;
        d[7:0] = 8'h1F;
        d[127:120] = 8'h03;
        send_beat(d, "R8 single lane");
        check(wire_inv == 16'h0001, "R8", "only lane 0 inverts (R1 lane0 = bits 7:0)", BUS_W'(wire_inv), BUS_W'(16'h0001));
        check(wire_dq[7:0] == 8'hE0 && wire_dq[127:120] == 8'h03 && wire_dq[119:8] == '0,
              "R1", "lane placement", wire_dq, {8'h03, 112'h0, 8'hE0});
    endtask

    task automatic t_idle_history();
        logic [BUS_W-1:0] held_dq;
        logic [LANES-1:0] held_inv;
        apply_reset();
        send_beat({LANES{8'hFF}}, "R5 first");
        held_dq  = wire_dq;
        held_inv = wire_inv;
        repeat (6) @(negedge clk);
        check(wire_dq == held_dq && wire_inv == held_inv, "R5", "hold over idle", wire_dq, held_dq);
        // Against 00/inv=1, 0x0F is 4+1 = 5 -> invert; against zero it would not be
        send_beat({LANES{8'h0F}}, "R5 coded against last word");
        check(wire_inv == {LANES{1'b1}} && wire_dq == {LANES{8'hF0}}, "R5", "history kept across gap",
              wire_dq, {LANES{8'hF0}});
    endtask

    task automatic t_decoder();
        loopback = 1'b0;
        ext_dq  = {LANES{8'h5A}};
        ext_inv = 16'hA5A5;
        #1;
        for (int l = 0; l < LANES; l++) begin
            logic [7:0] e;
            e = ext_inv[l] ? 8'hA5 : 8'h5A;
            check(rx_data[l*LANE_W +: LANE_W] == e, "R6", "decoder lane", BUS_W'(rx_data[l*LANE_W +: LANE_W]), BUS_W'(e));
        end
        loopback = 1'b1;
    endtask

    task automatic t_random_stream();
        apply_reset();
        for (int i = 0; i < 300; i++) begin
            logic [BUS_W-1:0] d;
            for (int w = 0; w < BUS_W / 32; w++) d[w*32 +: 32] = $urandom();
            send_beat(d, "R2 random");
            if (i % 37 == 0) repeat (3) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run ends as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        @(negedge clk);
        t_reset();
        t_full_flip();
        t_threshold();
        t_lane_independent();
        t_idle_history();
        t_decoder();
        t_random_stream();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule